// File: doc/BRIEF.md
# Packed Byte to Halfword Expander

This block widens packed signed samples. Each accepted 32-bit input word holds four signed 8-bit samples. The block sign-extends every sample to 16 bits and does not scale it. It then packs the four halfwords into two 32-bit result words and delivers both result words together on one output beat. Byte 0 is the least significant byte of the input word.

A per-word order select chooses how the samples are paired:
- Natural order puts neighbouring samples together: bytes 0 and 1, then bytes 2 and 3.
- Interleaved order puts bytes 0 and 2 together, then bytes 1 and 3.

A per-word endianness select exchanges the two result words.

Both streams use a valid/ready handshake. One output register sits between them. Latency is one cycle, and the block accepts one word per cycle while the consumer keeps accepting. The order and endianness selects are captured together with each word, so they may change from one word to the next.

Top module: `bx_expander`

## Requirements
- R1: Each input byte is sign-extended to a 16-bit halfword. Bit 7 of the byte is copied into bits 15..8, and no shift is applied. For example, 0x80 becomes 0xFF80, 0x7F becomes 0x007F and 0xFF becomes 0xFFFF.
- R2: Natural order and little-endian (`in_reorder`=0, `in_big_endian`=0):
  - word0 = `out_data[31:0]` = {hw(byte1), hw(byte0)}.
  - word1 = `out_data[63:32]` = {hw(byte3), hw(byte2)}.
  - byteN is `in_word[8N+7:8N]`.
  - In each word the lower-numbered byte sits in bits 15..0.
- R3: Interleaved order and little-endian (`in_reorder`=1, `in_big_endian`=0): word0 = {hw(byte2), hw(byte0)} and word1 = {hw(byte3), hw(byte1)}.
- R4: With `in_big_endian`=1, word0 and word1 swap contents relative to the little-endian result for the same order select. This holds in both orders.
- R5: A word accepted at a clock edge (`in_valid` and `in_ready` both high) appears with `out_valid` high right after that edge.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` does not change.
- R7: `in_ready` is high exactly when the output register is empty or `out_ready` is high. Every accepted word is delivered once, in order, and `out_valid` falls after a delivery that has no new acceptance in the same cycle.
- R8: Changes to `in_reorder` or `in_big_endian` while no word is accepted have no effect on `out_data`.
- R9: After reset, `out_valid` is low and `in_ready` is high.
- R10: With `in_valid` and `out_ready` held high, one word is accepted every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input word is valid |
| in_ready | output | 1 | Block can accept an input word |
| in_word | input | 32 | Four packed signed bytes, byte 0 in bits 7..0 |
| in_reorder | input | 1 | 0 selects natural pairing, 1 selects interleaved pairing |
| in_big_endian | input | 1 | 1 exchanges the two result words |
| out_valid | output | 1 | Result beat is valid |
| out_ready | input | 1 | Consumer accepts the result beat |
| out_data | output | 64 | word1 in bits 63..32, word0 in bits 31..0 |

## Verification
The bench drives the extreme byte values 0x80, 0x7F, 0xFF and 0x00. A design that zero-extends, or that shifts the sample, would show a wrong upper byte in the affected halfword. All four combinations of order and endianness are exercised against a behavioural model. A mixed-up pairing or a missing swap would put a halfword in the wrong lane. Long stalls are held while the mode inputs are toggled. A design that samples the selects combinationally, or that overwrites the held beat, would change `out_data` during the stall, and one that mishandles ready would drop or repeat a word. Back-to-back streaming catches a design that inserts a bubble after each beat.

// File: rtl/bx_pkg.sv
package bx_pkg;
  localparam int BX_BYTE_W = 8;
  localparam int BX_HALF_W = 16;

  typedef enum logic {
    ORD_NATURAL    = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } bx_order_e;
endpackage

// File: rtl/bx_lane_sext.sv
module bx_lane_sext #(
  parameter int IN_W  = 8,
  parameter int OUT_W = 16
) (
  input  logic [IN_W-1:0]  lane_in,
  output logic [OUT_W-1:0] lane_out
);
  localparam int EXT_W = OUT_W - IN_W;

  // Replicate the sign bit; the sample value is left unscaled.
  assign lane_out = {{EXT_W{lane_in[IN_W-1]}}, lane_in};
endmodule

// File: rtl/bx_pair_router.sv
module bx_pair_router
  import bx_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int HALF_W = 16
) (
  input  logic [LANES*HALF_W-1:0] halves,
  input  bx_order_e               order_sel,
  input  logic                    swap_words,
  output logic [LANES*HALF_W-1:0] words
);
  localparam int N_WORDS = LANES / 2;
  localparam int WORD_W  = 2 * HALF_W;

  logic [N_WORDS-1:0][WORD_W-1:0] paired;

  genvar w;
  generate
    for (w = 0; w < N_WORDS; w++) begin : g_pair
      logic [WORD_W-1:0] nat_word;
      logic [WORD_W-1:0] ilv_word;
      // Natural: neighbouring lanes 2w and 2w+1.
      assign nat_word = {halves[(2*w+1)*HALF_W +: HALF_W], halves[(2*w)*HALF_W +: HALF_W]};
      // Interleaved: lane w with lane w + N_WORDS.
      assign ilv_word = {halves[(w+N_WORDS)*HALF_W +: HALF_W], halves[w*HALF_W +: HALF_W]};
      assign paired[w] = (order_sel == ORD_INTERLEAVE) ? ilv_word : nat_word;
    end

    for (w = 0; w < N_WORDS; w++) begin : g_swap
      assign words[w*WORD_W +: WORD_W] = swap_words ? paired[N_WORDS-1-w] : paired[w];
    end
  endgenerate
endmodule

// File: rtl/bx_out_stage.sv
module bx_out_stage #(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              up_valid,
  output logic              up_ready,
  input  logic [DATA_W-1:0] up_data,
  output logic              dn_valid,
  input  logic              dn_ready,
  output logic [DATA_W-1:0] dn_data
);
  logic              valid_q, valid_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              load_en;

  assign up_ready = !valid_q || dn_ready;
  assign load_en  = up_valid && up_ready;

  always_comb begin
    valid_d = valid_q;
    data_d  = data_q;
    if (load_en) begin
      valid_d = 1'b1;
      data_d  = up_data;
    end else if (dn_ready) begin
      valid_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= valid_d;
      if (load_en) begin
        data_q <= data_d;
      end
    end
  end

  assign dn_valid = valid_q;
  assign dn_data  = data_q;

  AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid && !dn_ready |=> dn_valid && $stable(dn_data)) else $error("stall hold"); // R6

  AST_ONE_CYCLE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    up_valid && up_ready |=> dn_valid) else $error("latency"); // R5

  AST_DRAIN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid && dn_ready && !up_valid |=> !dn_valid) else $error("drain"); // R7

  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !dn_valid && !up_valid |=> !dn_valid) else $error("spurious beat"); // R7
endmodule

// File: rtl/bx_expander.sv
module bx_expander
  import bx_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  output logic                          in_ready,
  input  logic [LANES*BX_BYTE_W-1:0]    in_word,
  input  logic                          in_reorder,
  input  logic                          in_big_endian,
  output logic                          out_valid,
  input  logic                          out_ready,
  output logic [LANES*BX_HALF_W-1:0]    out_data
);
  localparam int IN_W  = LANES * BX_BYTE_W;
  localparam int OUT_W = LANES * BX_HALF_W;

  logic [OUT_W-1:0] halves;
  logic [OUT_W-1:0] routed;

  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : g_lane
      bx_lane_sext #(
        .IN_W  (BX_BYTE_W),
        .OUT_W (BX_HALF_W)
      ) u_sext (
        .lane_in  (in_word[g*BX_BYTE_W +: BX_BYTE_W]),
        .lane_out (halves[g*BX_HALF_W +: BX_HALF_W])
      );
    end
  endgenerate

  bx_pair_router #(
    .LANES  (LANES),
    .HALF_W (BX_HALF_W)
  ) u_router (
    .halves     (halves),
    .order_sel  (bx_order_e'(in_reorder)),
    .swap_words (in_big_endian),
    .words      (routed)
  );

  bx_out_stage #(
    .DATA_W (OUT_W)
  ) u_stage (
    .clk      (clk),
    .rst_n    (rst_n),
    .up_valid (in_valid),
    .up_ready (in_ready),
    .up_data  (routed),
    .dn_valid (out_valid),
    .dn_ready (out_ready),
    .dn_data  (out_data)
  );

  AST_LOW_LANE_SEXT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !in_big_endian |=>
      out_data[BX_HALF_W-1:0] == {{(BX_HALF_W-BX_BYTE_W){$past(in_word[BX_BYTE_W-1])}},
                                  $past(in_word[BX_BYTE_W-1:0])}) else $error("lane0"); // R1

  initial begin
    AST_WIDTH_OK: assert (IN_W * 2 == OUT_W && LANES % 2 == 0) else $error("widths"); // R2
  end
endmodule

// File: tb/bx_expander_tb_top.sv
module bx_expander_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_word = '0;
  logic        in_reorder = 1'b0;
  logic        in_big_endian = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [63:0] out_data;

  int n_cmp = 0;
  int n_bad = 0;

  logic [63:0] exp_q[$];
  string       tag_q[$];
  int          held = 0;

  always #10 clk = ~clk;

  bx_expander dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .in_reorder(in_reorder), .in_big_endian(in_big_endian),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  function automatic logic [63:0] model(logic [31:0] w, bit reo, bit be);
    logic [15:0] h [4];
    logic [31:0] first, second;
    for (int i = 0; i < 4; i++) begin
      int v = $signed(w[8*i +: 8]);
      h[i] = v[15:0];
    end
    if (!reo) begin
      first  = {h[1], h[0]};
      second = {h[3], h[2]};
    end else begin
      first  = {h[2], h[0]};
      second = {h[3], h[1]};
    end
    return be ? {first, second} : {second, first};
  endfunction

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One cycle: compare outputs, drive new inputs, advance model to next edge.
  task automatic step(bit iv, logic [31:0] w, bit reo, bit be, bit ordy);
    bit model_ready;
    @(negedge clk);
    chk(out_valid === (exp_q.size() != 0), "R5", {63'd0, out_valid}, {63'd0, exp_q.size() != 0});
    if (exp_q.size() != 0 && out_valid === 1'b1)
      chk(out_data === exp_q[0], (held > 0) ? "R6" : tag_q[0], out_data, exp_q[0]);
    in_valid = iv; in_word = w; in_reorder = reo; in_big_endian = be; out_ready = ordy;
    #1;
    model_ready = (exp_q.size() == 0) || ordy;
    chk(in_ready === model_ready, "R7", {63'd0, in_ready}, {63'd0, model_ready});
    if (exp_q.size() != 0) begin
      if (ordy) begin
        void'(exp_q.pop_front()); void'(tag_q.pop_front()); held = 0;
      end else begin
        held++;
      end
    end
    if (iv && model_ready) begin
      exp_q.push_back(model(w, reo, be));
      tag_q.push_back(be ? "R4" : (reo ? "R3" : "R2"));
      held = 0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #35;
    chk(out_valid === 1'b0, "R9", {63'd0, out_valid}, 64'd0);
    chk(in_ready === 1'b1, "R9", {63'd0, in_ready}, 64'd1);
    @(negedge clk); rst_n = 1'b1;

    // R1 extreme bytes, natural little-endian (R2 layout)
    step(1, 32'h7F80FF01, 0, 0, 1);
    step(0, 32'h0, 0, 0, 1);
    chk(out_data === 64'h007FFF80_FFFF0001, "R1", out_data, 64'h007FFF80_FFFF0001);
    step(0, 32'h0, 0, 0, 1);

    // R3 and R4 literal checks
    step(1, 32'h04830201, 1, 0, 1);
    step(0, 32'h0, 0, 0, 1);
    chk(out_data === 64'h00040002_FF830001, "R3", out_data, 64'h00040002_FF830001);
    step(1, 32'h04830201, 1, 1, 1);
    step(0, 32'h0, 0, 0, 1);
    chk(out_data === 64'hFF830001_00040002, "R4", out_data, 64'hFF830001_00040002);
    step(0, 32'h0, 0, 0, 1);

    // R6/R8: stall while toggling selects and word
    step(1, 32'h80FF7F00, 0, 0, 0);
    for (int k = 0; k < 4; k++) step(0, 32'hDEADBEEF, k[0], ~k[0], 0);
    chk(out_data === model(32'h80FF7F00, 0, 0), "R8", out_data, model(32'h80FF7F00, 0, 0));
    step(0, 32'h0, 0, 0, 1);
    step(0, 32'h0, 0, 0, 1);

    // R10: back-to-back streaming
    for (int k = 0; k < 8; k++) begin
      step(1, 32'h11223344 * (k + 1), k[0], k[1], 1);
      chk(in_ready === 1'b1, "R10", {63'd0, in_ready}, 64'd1);
    end
    step(0, 32'h0, 0, 0, 1);
    step(0, 32'h0, 0, 0, 1);

    // Random mix of patterns and back-pressure
    for (int k = 0; k < 3000; k++) begin
      logic [31:0] r;
      r = $urandom;
      step(($urandom % 10) < 7, r, $urandom % 2, $urandom % 2, ($urandom % 10) < 6);
    end
    for (int k = 0; k < 3; k++) step(0, 32'h0, 0, 0, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule